// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A memory-mapped controller for `NUM_PINS` general-purpose pins. The pins are grouped 32 to a register word.

Software reaches seven register banks through a simple read/write bus. The banks are:
- enable
- output data
- direction
- input level
- interrupt mask
- pending status
- edge select

The block drives the pad output value and a per-pin output enable. It samples the pad inputs through a two-flop synchronizer. It watches each synchronized pin for a selected edge and latches a pending bit when that edge occurs.

Pending bits are cleared by writing zero. A single registered interrupt line reports any pending pin whose mask bit is clear. An integrating subsystem places the block behind its bus fabric, wires the pad signals to the I/O ring and routes the interrupt line to its interrupt controller.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Bank base byte offsets are 0x00 enable, 0x10 output data, 0x20 direction, 0x30 input level, 0x40 mask, 0x50 pending, 0x60 edge select. Word w of a bank sits at base+4w, and pin n maps to bit n mod 32 of word n div 32. An address outside every bank, or not a multiple of 4, reads as zero, and a write to it changes no register.
- R2: Read data appears on `bus_rdata_o` at the clock edge that accepts the read request and holds until the next read.
- R3: `pad_o` equals the output-data bit. `pad_oe_o` is 1 only when the enable bit is 1 and the direction bit is 0; direction 1 means input.
- R4: After reset, enable is 0, output data is 0, direction is all 1, mask is all 1, edge select is 0, every pending bit is 0, and `irq_o` and `pad_oe_o` are 0.
- R5: Register bits for pins at or above `NUM_PINS` in the last word read as 0, and writes to them are ignored.
- R6: The input-level bank returns the two-flop synchronized level of every pin, whatever its direction.
- R7: Edge-select 1 makes a rising edge on the synchronized pin set the pending bit, and 0 selects a falling edge. The other edge sets nothing.
- R8: A pending bit latches whether or not its mask bit is set.
- R9: A write to the pending bank clears each bit written 0 and leaves each bit written 1. A new edge in the same cycle as the clear wins, and a write never sets a pending bit.
- R10: `irq_o` is a register holding the OR of all pending bits whose mask bit is 0. A mask bit of 1 blocks that pin.
- R11: Writes to the input-level bank have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pad_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The following properties are checked on every cycle:
- No output enable is ever asserted without its enable bit.
- The interrupt line only rises when an unmasked pending bit existed one cycle earlier.
- A pending bit only appears after a change on the synchronized level.
- A pending bit only disappears after a write to the pending bank.
- All outputs and pending bits are quiet on the first cycle after reset.

Other behaviour can only be shown by the bench's scenarios:
- The address decode and truncation of the last word.
- The choice of rising versus falling edge per pin.
- The bit-selective clear.
- The masked pins that latch but stay silent until unmasked.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_BANKS = 7;

  // order must match the bank base list in gpio_addr_dec
  typedef enum logic [2:0] {
    BK_EN   = 3'd0,
    BK_WD   = 3'd1,
    BK_DIR  = 3'd2,
    BK_LVL  = 3'd3,
    BK_MSK  = 3'd4,
    BK_PND  = 3'd5,
    BK_EDG  = 3'd6,
    BK_NONE = 3'd7
  } bank_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NWORDS  = 2,
  parameter int WIDX_W  = 1,
  parameter int EN_OFS  = 'h00,
  parameter int WD_OFS  = 'h10,
  parameter int DIR_OFS = 'h20,
  parameter int LVL_OFS = 'h30,
  parameter int MSK_OFS = 'h40,
  parameter int PND_OFS = 'h50,
  parameter int EDG_OFS = 'h60
) (
  input  logic [ADDR_W-1:0] addr_i,
  output bank_e             bank_o,
  output logic [WIDX_W-1:0] word_o
);
  localparam int SPAN = 4 * NWORDS;
  localparam int BASES [NUM_BANKS] = '{EN_OFS, WD_OFS, DIR_OFS, LVL_OFS,
                                       MSK_OFS, PND_OFS, EDG_OFS};

  always_comb begin
    bank_o = BK_NONE;
    word_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      int off;
      off = int'(addr_i) - BASES[b];
      if (off >= 0 && off < SPAN && (off % 4) == 0) begin
        bank_o = bank_e'(3'(b));
        word_o = WIDX_W'(off / 4);
      end
    end
  end
endmodule

// File: rtl/gpio_bank_reg.sv
module gpio_bank_reg #(
  parameter int   NUM_PINS = 40,
  parameter int   WIDX_W   = 1,
  parameter logic RST_BIT  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [WIDX_W-1:0]   word_i,
  input  logic [31:0]         wdata_i,
  output logic [NUM_PINS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= {NUM_PINS{RST_BIT}};
    end else if (wr_i) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (int'(word_i) == p / 32) q_o[p] <= wdata_i[p % 32];
      end
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int NUM_PINS = 40,
  parameter int WIDX_W   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] rise_sel_i,
  input  logic                clr_wr_i,
  input  logic [WIDX_W-1:0]   clr_word_i,
  input  logic [31:0]         clr_data_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] clr;

  assign hit = (rise_sel_i & lvl_i & ~prev_q) | (~rise_sel_i & ~lvl_i & prev_q);

  always_comb begin
    clr = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      clr[p] = clr_wr_i && (int'(clr_word_i) == p / 32) && !clr_data_i[p % 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_o <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_o <= (pend_o & ~clr) | hit;  // new edge beats a same-cycle clear
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8,
  parameter int EN_OFS   = 'h00,
  parameter int WD_OFS   = 'h10,
  parameter int DIR_OFS  = 'h20,
  parameter int LVL_OFS  = 'h30,
  parameter int MSK_OFS  = 'h40,
  parameter int PND_OFS  = 'h50,
  parameter int EDG_OFS  = 'h60
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int NWORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int PAD_W  = NWORDS * WORD_W;

  bank_e               bank;
  logic [WIDX_W-1:0]   word;
  logic                wr, rd, st_wr;
  logic [NUM_PINS-1:0] en_q, wd_q, dir_q, im_q, et_q, lvl_q, pend_q;
  logic [NUM_PINS-1:0] rd_vec;
  logic [PAD_W-1:0]    rd_pad;
  logic [31:0]         rdata_q;
  logic                irq_q;

  assign wr    = bus_req_i & bus_we_i;
  assign rd    = bus_req_i & ~bus_we_i;
  assign st_wr = wr && (bank == BK_PND);

  gpio_addr_dec #(
    .ADDR_W(ADDR_W), .NWORDS(NWORDS), .WIDX_W(WIDX_W),
    .EN_OFS(EN_OFS), .WD_OFS(WD_OFS), .DIR_OFS(DIR_OFS), .LVL_OFS(LVL_OFS),
    .MSK_OFS(MSK_OFS), .PND_OFS(PND_OFS), .EDG_OFS(EDG_OFS)
  ) u_dec (
    .addr_i(bus_addr_i),
    .bank_o(bank),
    .word_o(word)
  );

  gpio_bank_reg #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W), .RST_BIT(1'b0)) u_en (
    .clk_i, .rst_ni, .wr_i(wr && bank == BK_EN), .word_i(word),
    .wdata_i(bus_wdata_i), .q_o(en_q));

  gpio_bank_reg #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W), .RST_BIT(1'b0)) u_wd (
    .clk_i, .rst_ni, .wr_i(wr && bank == BK_WD), .word_i(word),
    .wdata_i(bus_wdata_i), .q_o(wd_q));

  gpio_bank_reg #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W), .RST_BIT(1'b1)) u_dir (
    .clk_i, .rst_ni, .wr_i(wr && bank == BK_DIR), .word_i(word),
    .wdata_i(bus_wdata_i), .q_o(dir_q));

  gpio_bank_reg #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W), .RST_BIT(1'b1)) u_msk (
    .clk_i, .rst_ni, .wr_i(wr && bank == BK_MSK), .word_i(word),
    .wdata_i(bus_wdata_i), .q_o(im_q));

  gpio_bank_reg #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W), .RST_BIT(1'b0)) u_edg (
    .clk_i, .rst_ni, .wr_i(wr && bank == BK_EDG), .word_i(word),
    .wdata_i(bus_wdata_i), .q_o(et_q));

  gpio_sync2 #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(lvl_q));

  gpio_edge_det #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W)) u_det (
    .clk_i, .rst_ni,
    .lvl_i(lvl_q), .rise_sel_i(et_q),
    .clr_wr_i(st_wr), .clr_word_i(word), .clr_data_i(bus_wdata_i),
    .pend_o(pend_q));

  always_comb begin
    unique case (bank)
      BK_EN:   rd_vec = en_q;
      BK_WD:   rd_vec = wd_q;
      BK_DIR:  rd_vec = dir_q;
      BK_LVL:  rd_vec = lvl_q;
      BK_MSK:  rd_vec = im_q;
      BK_PND:  rd_vec = pend_q;
      BK_EDG:  rd_vec = et_q;
      default: rd_vec = '0;
    endcase
  end
  assign rd_pad = PAD_W'(rd_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_pad[int'(word) * WORD_W +: WORD_W];
      irq_q <= |(pend_q & ~im_q);
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign pad_o       = wd_q;
  assign pad_oe_o    = en_q & ~dir_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NUM_PINS = 40
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] im_q,
  input logic [NUM_PINS-1:0] pend_q,
  input logic [NUM_PINS-1:0] lvl_q,
  input logic                st_wr
);
  // R3
  oe_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~en_q) == '0);

  // R10
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(pend_q & ~im_q)));

  // R7
  pend_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q)) & ~($past(lvl_q) ^ $past(lvl_q, 2))) == '0);

  // R9
  pend_clear_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_q) & ~pend_q)) |-> $past(st_wr));

  // R4
  reset_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (pad_oe_o == '0 && !irq_o && pend_q == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pad_oe_o(pad_oe_o), .irq_o(irq_o),
  .en_q(en_q), .im_q(im_q), .pend_q(pend_q), .lvl_q(lvl_q), .st_wr(st_wr));

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
  localparam int NP = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_req_i = 1'b0;
  logic          bus_we_i = 1'b0;
  logic [7:0]    bus_addr_i = '0;
  logic [31:0]   bus_wdata_i = '0;
  logic [31:0]   bus_rdata_o;
  logic [NP-1:0] pad_i = '0;
  logic [NP-1:0] pad_o, pad_oe_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_edge_ctrl u0 (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .pad_i, .pad_o, .pad_oe_o, .irq_o);

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [9] = '{
    {8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {8'h04, 32'hFFFF_FFFF, 32'h0000_00FF},
    {8'h10, 32'h1234_5678, 32'h1234_5678},
    {8'h24, 32'h0000_1234, 32'h0000_0034},
    {8'h44, 32'hFFFF_FF00, 32'h0000_0000},
    {8'h64, 32'hAAAA_AAAA, 32'h0000_00AA},
    {8'h70, 32'hDEAD_BEEF, 32'h0000_0000},
    {8'h32, 32'h5A5A_5A5A, 32'h0000_0000},
    {8'h30, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    @(negedge clk_i);
    bus_req_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic set_pad(input int n, input logic v);
    @(negedge clk_i);
    pad_i[n] = v;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R4 reset state
    chk("R4 oe", 64'(pad_oe_o), 64'h0);
    chk("R4 irq", 64'(irq_o), 64'h0);
    bus_read(8'h00, rd); chk("R4 en0", 64'(rd), 64'h0);
    bus_read(8'h20, rd); chk("R4 dir0", 64'(rd), 64'hFFFF_FFFF);
    bus_read(8'h24, rd); chk("R5 dir1", 64'(rd), 64'h0000_00FF);
    bus_read(8'h40, rd); chk("R4 msk0", 64'(rd), 64'hFFFF_FFFF);
    bus_read(8'h50, rd); chk("R4 pnd0", 64'(rd), 64'h0);
    bus_read(8'h60, rd); chk("R4 edg0", 64'(rd), 64'h0);

    // R1 map, R2 read latency, R5 truncation, R11 input bank read-only
    for (int i = 0; i < 9; i++) begin
      bus_write(VEC[i][71:64], VEC[i][63:32]);
      bus_read(VEC[i][71:64], rd);
      chk("R1/R2/R5/R11 table", 64'(rd), 64'(VEC[i][31:0]));
    end

    // R3 pad drive
    chk("R3 pad_o", 64'(pad_o), 64'h00_1234_5678);
    chk("R3 oe dir", 64'(pad_oe_o), 64'hCB_0000_0000);
    bus_write(8'h20, 32'h0);
    chk("R3 oe out", 64'(pad_oe_o), 64'hCB_A5A5_0F0F);
    bus_write(8'h00, 32'h0);
    chk("R3 oe en", 64'(pad_oe_o), 64'hCB_0000_0000);

    // R6 sampled level regardless of direction
    @(negedge clk_i) pad_i = 40'hC3_0F1E_2D3C;
    repeat (4) @(negedge clk_i);
    bus_read(8'h30, rd); chk("R6 lvl0", 64'(rd), 64'h0F1E_2D3C);
    bus_read(8'h34, rd); chk("R6 lvl1", 64'(rd), 64'h0000_00C3);
    @(negedge clk_i) pad_i = '0;
    repeat (4) @(negedge clk_i);

    // clean state for edge tests
    bus_write(8'h50, 32'h0);
    bus_write(8'h54, 32'h0);
    bus_write(8'h60, 32'h0000_0020);
    bus_write(8'h40, 32'hFFFF_FFDF);
    bus_write(8'h44, 32'h0000_00FF);
    repeat (2) @(negedge clk_i);
    chk("R10 irq idle", 64'(irq_o), 64'h0);

    set_pad(5, 1'b1);
    bus_read(8'h50, rd); chk("R7 rise", 64'(rd), 64'h20);
    chk("R10 irq unmasked", 64'(irq_o), 64'h1);
    set_pad(6, 1'b1);
    bus_read(8'h50, rd); chk("R7 rise ignored", 64'(rd), 64'h20);
    set_pad(6, 1'b0);
    bus_read(8'h50, rd); chk("R7 R8 fall masked", 64'(rd), 64'h60);

    bus_write(8'h50, 32'hFFFF_FFDF);
    bus_read(8'h50, rd); chk("R9 clear zero", 64'(rd), 64'h40);
    repeat (2) @(negedge clk_i);
    chk("R10 masked quiet", 64'(irq_o), 64'h0);
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_read(8'h50, rd); chk("R9 one keeps", 64'(rd), 64'h40);

    set_pad(39, 1'b1);
    bus_read(8'h54, rd); chk("R8 top pin", 64'(rd), 64'h80);
    chk("R10 masked top", 64'(irq_o), 64'h0);
    bus_write(8'h44, 32'h0000_007F);
    repeat (2) @(negedge clk_i);
    chk("R10 unmask top", 64'(irq_o), 64'h1);
    bus_write(8'h54, 32'h0);
    repeat (2) @(negedge clk_i);
    bus_read(8'h54, rd); chk("R9 clear top", 64'(rd), 64'h0);
    chk("R10 irq cleared", 64'(irq_o), 64'h0);

    set_pad(5, 1'b0);
    bus_read(8'h50, rd); chk("R7 fall ignored", 64'(rd), 64'h40);

    finish_run();
  end
endmodule